// File: doc/BRIEF.md
# Interrupt Presenter CAM Matcher

The matcher takes one interrupt notification aimed at a virtual thread and decides which hardware thread, and which ring of that thread's context, should receive it. A notification carries a block number, an index, a format bit, an ignore bit, a priority and a logical-server number. The matcher compares it at once against the ring context words of all `N_THR` hardware threads.

When exactly one thread matches, it emits a post strobe with the thread number, the ring code and the priority. The context logic of that thread then sets the pending bit and runs its notify check. When no thread matches, it emits a backlog strobe so that the priority can be stored in the pending bitmap of the virtual-thread record. A second matching thread, or a virtual-thread record that is not valid, drops the notification and raises an error strobe instead.

All results are registered and appear one cycle after the request strobe.

Top module: `ipm_cam_matcher`

## Requirements
- R1: The target CAM value is the request block shifted left by `IDX_W` (19 by default) and ORed with the request index, so it equals the concatenation {block, index}.
- R2: The physical CAM of a thread is wired from its processor ID. Its block is PID bits 11:8. Its index is 0x80 ORed with PID bits 6:0. PID bit 7 and the bits above 11 are not used.
- R3: With format 0 and ignore 0, each thread tests its rings in a fixed order: physical (valid bit and hardwired CAM), then pool (valid bit and pool CAM), then OS (valid bit and OS CAM). The first ring that hits is the result. Ring codes on `post_ring` are 3 = physical, 2 = pool, 1 = OS, 0 = user.
- R4: With format 0 and ignore 1, no thread matches. A valid request then produces a backlog strobe.
- R5: With format 1, only the user ring (code 0) can match. It needs the OS valid bit set, the OS CAM equal to the target, the user valid bit set, and the user logical-server field equal to the request's logical-server number.
- R6: If two or more threads match, `err_dup` pulses and neither a post strobe nor a backlog strobe is produced.
- R7: If `req_rec_valid` is low, `err_inval` pulses and no other outcome strobe is produced, whatever the contexts hold.
- R8: If exactly one thread matches, `post_valid` pulses with `post_tid` set to that thread's number, `post_ring` set to the winning ring, and `evt_prio` set to the request priority.
- R9: If no thread matches a valid request, `backlog_valid` pulses with `evt_prio` set to the request priority.
- R10: Every outcome appears in the cycle after the request strobe, lasts one cycle, and is exclusive of the others. There are no strobes without a request, and all strobes are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Notification strobe |
| req_fmt | input | 1 | Format bit (1 selects the user ring) |
| req_ign | input | 1 | Ignore bit (logical-server group request) |
| req_blk | input | BLK_W | Target block number |
| req_idx | input | IDX_W | Target index |
| req_prio | input | PRIO_W | Notification priority |
| req_lsrv | input | LS_W | Requested logical-server number |
| req_rec_valid | input | 1 | Virtual-thread record valid |
| thr_pid | input | N_THR*PID_W | Processor ID of each thread |
| thr_phys_vld | input | N_THR | Physical ring valid bit per thread |
| thr_pool_vld | input | N_THR | Pool ring valid bit per thread |
| thr_pool_cam | input | N_THR*CAM_W | Pool ring CAM per thread |
| thr_os_vld | input | N_THR | OS ring valid bit per thread |
| thr_os_cam | input | N_THR*CAM_W | OS ring CAM per thread |
| thr_usr_vld | input | N_THR | User ring valid bit per thread |
| thr_usr_ls | input | N_THR*LS_W | User ring logical-server field per thread |
| post_valid | output | 1 | Post strobe for the matched thread |
| post_tid | output | TID_W | Matched thread number |
| post_ring | output | 2 | Matched ring code |
| evt_prio | output | PRIO_W | Priority carried with a post or backlog strobe |
| backlog_valid | output | 1 | No thread matched; record the priority in the backlog |
| err_dup | output | 1 | More than one thread matched |
| err_inval | output | 1 | Virtual-thread record invalid |

## Verification
The bench uses the default widths with four threads. Four threads are enough to produce single hits, hits in several threads at once, and hits in the last thread that the selection scan reaches. Processor IDs are drawn with bit 7 and the high bits randomised, so a wrong hardwired CAM encoding leads to false hits or missed hits. Blocks and indexes come from small sets, so random contexts often collide with the target, and all three format-0 rings as well as the user ring win regularly.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
    typedef enum logic [1:0] {
        RING_USR  = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;
endpackage

// File: rtl/ipm_thread_cmp.sv
module ipm_thread_cmp
    import ipm_pkg::*;
#(
    parameter int BLK_W = 4,
    parameter int IDX_W = 19,
    parameter int PID_W = 12,
    parameter int LS_W  = 4,
    localparam int CAM_W = BLK_W + IDX_W
) (
    input  logic             fmt,
    input  logic             ign,
    input  logic [CAM_W-1:0] tgt_cam,
    input  logic [LS_W-1:0]  lsrv,
    input  logic [PID_W-1:0] pid,
    input  logic             phys_vld,
    input  logic             pool_vld,
    input  logic [CAM_W-1:0] pool_cam,
    input  logic             os_vld,
    input  logic [CAM_W-1:0] os_cam,
    input  logic             usr_vld,
    input  logic [LS_W-1:0]  usr_ls,
    output logic             hit,
    output ring_e            ring
);
    // Hardwired physical CAM: block from PID[11:8], index = 0x80 | PID[6:0]
    logic [BLK_W-1:0] hw_blk;
    logic [IDX_W-1:0] hw_idx;
    logic [CAM_W-1:0] hw_cam;

    assign hw_blk = BLK_W'(pid[11:8]);
    assign hw_idx = IDX_W'({1'b1, pid[6:0]});
    assign hw_cam = {hw_blk, hw_idx};

    always_comb begin
        hit  = 1'b0;
        ring = RING_USR;
        if (!fmt) begin
            if (!ign) begin
                if (phys_vld && (tgt_cam == hw_cam)) begin
                    hit  = 1'b1;
                    ring = RING_PHYS;
                end else if (pool_vld && (tgt_cam == pool_cam)) begin
                    hit  = 1'b1;
                    ring = RING_POOL;
                end else if (os_vld && (tgt_cam == os_cam)) begin
                    hit  = 1'b1;
                    ring = RING_OS;
                end
            end
        end else if (os_vld && (tgt_cam == os_cam) && usr_vld && (usr_ls == lsrv)) begin
            hit  = 1'b1;
            ring = RING_USR;
        end
    end

    always_comb begin
        if (hit && fmt) assert (ring == RING_USR) else $error("AST_FMT1_USER_ONLY"); // R5
    end
endmodule

// File: rtl/ipm_hit_select.sv
module ipm_hit_select
    import ipm_pkg::*;
#(
    parameter int N_THR = 4,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic [N_THR-1:0] hits,
    input  ring_e            rings [N_THR],
    output logic             any_hit,
    output logic             multi_hit,
    output logic [TID_W-1:0] sel_tid,
    output ring_e            sel_ring
);
    always_comb begin
        any_hit   = |hits;
        multi_hit = (hits & (hits - N_THR'(1))) != '0;
        sel_tid   = '0;
        sel_ring  = RING_USR;
        for (int i = N_THR - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel_tid  = TID_W'(i);
                sel_ring = rings[i];
            end
        end
    end

    always_comb begin
        if (!multi_hit && any_hit) assert ($onehot(hits)) else $error("AST_SINGLE_HIT"); // R6
    end
endmodule

// File: rtl/ipm_cam_matcher.sv
module ipm_cam_matcher
    import ipm_pkg::*;
#(
    parameter int N_THR  = 4,
    parameter int BLK_W  = 4,
    parameter int IDX_W  = 19,
    parameter int PID_W  = 12,
    parameter int LS_W   = 4,
    parameter int PRIO_W = 3,
    localparam int CAM_W = BLK_W + IDX_W,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_fmt,
    input  logic                    req_ign,
    input  logic [BLK_W-1:0]        req_blk,
    input  logic [IDX_W-1:0]        req_idx,
    input  logic [PRIO_W-1:0]       req_prio,
    input  logic [LS_W-1:0]         req_lsrv,
    input  logic                    req_rec_valid,
    input  logic [N_THR*PID_W-1:0]  thr_pid,
    input  logic [N_THR-1:0]        thr_phys_vld,
    input  logic [N_THR-1:0]        thr_pool_vld,
    input  logic [N_THR*CAM_W-1:0]  thr_pool_cam,
    input  logic [N_THR-1:0]        thr_os_vld,
    input  logic [N_THR*CAM_W-1:0]  thr_os_cam,
    input  logic [N_THR-1:0]        thr_usr_vld,
    input  logic [N_THR*LS_W-1:0]   thr_usr_ls,
    output logic                    post_valid,
    output logic [TID_W-1:0]        post_tid,
    output logic [1:0]              post_ring,
    output logic [PRIO_W-1:0]       evt_prio,
    output logic                    backlog_valid,
    output logic                    err_dup,
    output logic                    err_inval
);
    typedef struct packed {
        logic              post;
        logic              backlog;
        logic              dup;
        logic              inval;
        logic [TID_W-1:0]  tid;
        ring_e             ring;
        logic [PRIO_W-1:0] prio;
    } out_t;

    logic [CAM_W-1:0] tgt_cam;
    logic [N_THR-1:0] hits;
    ring_e            rings [N_THR];
    logic             any_hit;
    logic             multi_hit;
    logic [TID_W-1:0] sel_tid;
    ring_e            sel_ring;
    out_t             out_d, out_q;

    assign tgt_cam = {req_blk, req_idx};

    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        ipm_thread_cmp #(
            .BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W), .LS_W(LS_W)
        ) u_cmp (
            .fmt      (req_fmt),
            .ign      (req_ign),
            .tgt_cam  (tgt_cam),
            .lsrv     (req_lsrv),
            .pid      (thr_pid[t*PID_W +: PID_W]),
            .phys_vld (thr_phys_vld[t]),
            .pool_vld (thr_pool_vld[t]),
            .pool_cam (thr_pool_cam[t*CAM_W +: CAM_W]),
            .os_vld   (thr_os_vld[t]),
            .os_cam   (thr_os_cam[t*CAM_W +: CAM_W]),
            .usr_vld  (thr_usr_vld[t]),
            .usr_ls   (thr_usr_ls[t*LS_W +: LS_W]),
            .hit      (hits[t]),
            .ring     (rings[t])
        );
    end

    ipm_hit_select #(.N_THR(N_THR)) u_sel (
        .hits      (hits),
        .rings     (rings),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .sel_tid   (sel_tid),
        .sel_ring  (sel_ring)
    );

    always_comb begin
        out_d      = '0;
        out_d.tid  = sel_tid;
        out_d.ring = sel_ring;
        out_d.prio = req_prio;
        if (req_valid) begin
            if (!req_rec_valid)  out_d.inval   = 1'b1;
            else if (multi_hit)  out_d.dup     = 1'b1;
            else if (any_hit)    out_d.post    = 1'b1;
            else                 out_d.backlog = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign post_valid    = out_q.post;
    assign post_tid      = out_q.tid;
    assign post_ring     = out_q.ring;
    assign evt_prio      = out_q.prio;
    assign backlog_valid = out_q.backlog;
    assign err_dup       = out_q.dup;
    assign err_inval     = out_q.inval;

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({post_valid, backlog_valid, err_dup, err_inval})); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(post_valid || backlog_valid || err_dup || err_inval)); // R10
    AST_INVAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_rec_valid) |=> err_inval); // R7
    AST_GROUP_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rec_valid && !req_fmt && req_ign) |=> backlog_valid); // R4
    AST_PRIO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (evt_prio == $past(req_prio))); // R8
    AST_USER_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fmt) |=> (!post_valid || post_ring == RING_USR)); // R5
endmodule

// File: tb/ipm_cam_matcher_bench.sv
module ipm_cam_matcher_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_THR  = 4;
    localparam int BLK_W  = 4;
    localparam int IDX_W  = 19;
    localparam int PID_W  = 12;
    localparam int LS_W   = 4;
    localparam int PRIO_W = 3;
    localparam int CAM_W  = BLK_W + IDX_W;
    localparam int TID_W  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_fmt = 1'b0, req_ign = 1'b0, req_rec_valid = 1'b0;
    logic [BLK_W-1:0]  req_blk = '0;
    logic [IDX_W-1:0]  req_idx = '0;
    logic [PRIO_W-1:0] req_prio = '0;
    logic [LS_W-1:0]   req_lsrv = '0;

    logic [PID_W-1:0] a_pid [N_THR];
    logic [CAM_W-1:0] a_pool [N_THR];
    logic [CAM_W-1:0] a_os [N_THR];
    logic [LS_W-1:0]  a_ls [N_THR];
    logic [N_THR-1:0] phys_v = '0, pool_v = '0, os_v = '0, usr_v = '0;

    logic [N_THR*PID_W-1:0] f_pid;
    logic [N_THR*CAM_W-1:0] f_pool, f_os;
    logic [N_THR*LS_W-1:0]  f_ls;

    logic              post_valid, backlog_valid, err_dup, err_inval;
    logic [TID_W-1:0]  post_tid;
    logic [1:0]        post_ring;
    logic [PRIO_W-1:0] evt_prio;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int t = 0; t < N_THR; t++) begin
            f_pid[t*PID_W +: PID_W]  = a_pid[t];
            f_pool[t*CAM_W +: CAM_W] = a_pool[t];
            f_os[t*CAM_W +: CAM_W]   = a_os[t];
            f_ls[t*LS_W +: LS_W]     = a_ls[t];
        end
    end

    ipm_cam_matcher #(
        .N_THR(N_THR), .BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W),
        .LS_W(LS_W), .PRIO_W(PRIO_W)
    ) u_ipm_cam_matcher (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
        .req_ign(req_ign), .req_blk(req_blk), .req_idx(req_idx),
        .req_prio(req_prio), .req_lsrv(req_lsrv), .req_rec_valid(req_rec_valid),
        .thr_pid(f_pid), .thr_phys_vld(phys_v), .thr_pool_vld(pool_v),
        .thr_pool_cam(f_pool), .thr_os_vld(os_v), .thr_os_cam(f_os),
        .thr_usr_vld(usr_v), .thr_usr_ls(f_ls),
        .post_valid(post_valid), .post_tid(post_tid), .post_ring(post_ring),
        .evt_prio(evt_prio), .backlog_valid(backlog_valid),
        .err_dup(err_dup), .err_inval(err_inval)
    );

    // outcome codes: 0 none, 1 post, 2 backlog, 3 dup, 4 inval
    function automatic int outcome_now();
        if (post_valid)    return 1;
        if (backlog_valid) return 2;
        if (err_dup)       return 3;
        if (err_inval)     return 4;
        return 0;
    endfunction

    function automatic void ref_model(input logic fmt, input logic ign,
                                      input logic [BLK_W-1:0] blk, input logic [IDX_W-1:0] idx,
                                      input logic [LS_W-1:0] ls, input logic rec,
                                      output int oc, output int tid, output int ring);
        logic [31:0] tgt, hw;
        int nhit;
        tgt  = (32'(blk) << IDX_W) | 32'(idx);   // R1
        nhit = 0; tid = 0; ring = 0;
        for (int t = 0; t < N_THR; t++) begin
            int r;
            r  = -1;
            hw = (32'(a_pid[t][11:8]) << IDX_W) | 32'h80 | 32'(a_pid[t][6:0]);  // R2
            if (!fmt && !ign) begin                                               // R3
                if (phys_v[t] && tgt == hw) r = 3;
                else if (pool_v[t] && tgt == 32'(a_pool[t])) r = 2;
                else if (os_v[t] && tgt == 32'(a_os[t])) r = 1;
            end else if (fmt) begin                                               // R5
                if (os_v[t] && tgt == 32'(a_os[t]) && usr_v[t] && a_ls[t] == ls) r = 0;
            end
            if (r >= 0) begin
                if (nhit == 0) begin tid = t; ring = r; end
                nhit++;
            end
        end
        if (!rec)          oc = 4;
        else if (nhit > 1) oc = 3;
        else if (nhit == 1) oc = 1;
        else               oc = 2;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic fmt, input logic ign, input logic [BLK_W-1:0] blk,
                        input logic [IDX_W-1:0] idx, input logic [PRIO_W-1:0] prio,
                        input logic [LS_W-1:0] ls, input logic rec, input string tag);
        int oc, tid, ring;
        ref_model(fmt, ign, blk, idx, ls, rec, oc, tid, ring);
        @(negedge clk);
        req_valid = 1'b1; req_fmt = fmt; req_ign = ign; req_blk = blk;
        req_idx = idx; req_prio = prio; req_lsrv = ls; req_rec_valid = rec;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " outcome"}, outcome_now(), oc);
        if (oc == 1) begin
            chk({tag, " R8 tid"}, int'(post_tid), tid);
            chk({tag, " R3 ring"}, int'(post_ring), ring);
        end
        if (oc == 1 || oc == 2) chk({tag, " R9 prio"}, int'(evt_prio), int'(prio));
        @(negedge clk);
        chk({tag, " R10 one-cycle strobe"}, outcome_now(), 0);
    endtask

    task automatic clear_ctx();
        for (int t = 0; t < N_THR; t++) begin
            a_pid[t] = PID_W'(t); a_pool[t] = '1; a_os[t] = '1; a_ls[t] = '0;
        end
        phys_v = '0; pool_v = '0; os_v = '0; usr_v = '0;
    endtask

    function automatic logic [IDX_W-1:0] pick_idx();
        case ($urandom % 3)
            0: return IDX_W'('h80);
            1: return IDX_W'('h81);
            default: return IDX_W'('h05);
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        clear_ctx();
        repeat (3) @(negedge clk);
        chk("R10 reset outcome", outcome_now(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", outcome_now(), 0);

        // R2/R3: thread 2 PID 0x2_8_05 (bit7 set, ignored) -> hw cam {2, 0x85}
        clear_ctx();
        a_pid[2] = 12'h285; phys_v[2] = 1'b1;
        a_pool[2] = {4'd2, 19'h85}; pool_v[2] = 1'b1;
        a_os[2] = {4'd2, 19'h85}; os_v[2] = 1'b1;
        send(1'b0, 1'b0, 4'd2, 19'h85, 3'd5, '0, 1'b1, "R2 R3 phys first");
        phys_v[2] = 1'b0;
        send(1'b0, 1'b0, 4'd2, 19'h85, 3'd6, '0, 1'b1, "R3 pool before os");
        pool_v[2] = 1'b0;
        send(1'b0, 1'b0, 4'd2, 19'h85, 3'd1, '0, 1'b1, "R3 os only");
        // R2: index lacks 0x80 -> no physical match
        phys_v[2] = 1'b1; os_v[2] = 1'b0;
        send(1'b0, 1'b0, 4'd2, 19'h05, 3'd2, '0, 1'b1, "R2 index needs 0x80");
        // R4: group request ignored even with a hit present
        send(1'b0, 1'b1, 4'd2, 19'h85, 3'd3, '0, 1'b1, "R4 group unsupported");
        // R5: user ring
        clear_ctx();
        a_os[3] = {4'd1, 19'h81}; os_v[3] = 1'b1; usr_v[3] = 1'b1; a_ls[3] = 4'd9;
        send(1'b1, 1'b0, 4'd1, 19'h81, 3'd4, 4'd9, 1'b1, "R5 user hit");
        send(1'b1, 1'b0, 4'd1, 19'h81, 3'd4, 4'd8, 1'b1, "R5 ls mismatch");
        usr_v[3] = 1'b0;
        send(1'b1, 1'b0, 4'd1, 19'h81, 3'd4, 4'd9, 1'b1, "R5 user invalid");
        // R6: duplicate
        clear_ctx();
        a_os[0] = {4'd3, 19'h80}; os_v[0] = 1'b1;
        a_pool[1] = {4'd3, 19'h80}; pool_v[1] = 1'b1;
        send(1'b0, 1'b0, 4'd3, 19'h80, 3'd7, '0, 1'b1, "R6 duplicate");
        // R7: invalid record with a match present
        send(1'b0, 1'b0, 4'd3, 19'h80, 3'd7, '0, 1'b0, "R7 invalid record");
        // R9: no match
        send(1'b0, 1'b0, 4'd0, 19'h05, 3'd0, '0, 1'b1, "R9 backlog");

        // random mix
        for (int n = 0; n < 400; n++) begin
            for (int t = 0; t < N_THR; t++) begin
                a_pid[t]  = PID_W'((($urandom % 3) << 8) | ($urandom & 32'h80) | ($urandom % 2));
                a_pool[t] = {BLK_W'($urandom % 3), pick_idx()};
                a_os[t]   = {BLK_W'($urandom % 3), pick_idx()};
                a_ls[t]   = LS_W'($urandom % 2);
                phys_v[t] = ($urandom % 3) == 0;
                pool_v[t] = ($urandom % 3) == 0;
                os_v[t]   = ($urandom % 3) == 0;
                usr_v[t]  = ($urandom % 2) == 0;
            end
            send(($urandom % 4) == 0, ($urandom % 8) == 0, BLK_W'($urandom % 3), pick_idx(),
                 PRIO_W'($urandom), LS_W'($urandom % 2), ($urandom % 10) != 0, "R1 R8 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule